// File: doc/BRIEF.md
# Banked Speculation Control Register

This block holds a processor's speculation-control word as two banked copies, one owned by the host and one by the currently running guest. In host mode only the host copy drives the speculation-control outputs, and register accesses reach only the host copy. A guest-entry strobe makes the block fetch the guest copy from a fixed slot in the per-guest control block in memory. Guest mode begins only once that fetch returns. While the guest runs, the effective control word is the bitwise OR of both copies. The host can therefore enforce a minimum setting that the guest cannot clear.

A guest-exit strobe makes the block store the guest copy back to the same slot. When the store is acknowledged, the block returns to host-only behaviour and clears its internal guest copy. Memory traffic uses one outstanding single-word request at a time, on a valid/ready request channel and a valid/ready response channel. The request holds steady while `mem_req_ready` is low. Exactly one response follows each accepted request, and it is taken in any cycle where `mem_rsp_valid` is high, since `mem_rsp_ready` is high throughout the wait. The block reports its presence through a constant capability word and needs no enable bit.

Top module: `spec_ctrl_bank`

## Requirements
- R1: After reset both copies are zero, the block is in host mode, not busy, `proto_err` is 0, and `eff_ctrl` and `reg_rd_data` read 0.
- R2: In host mode a register write updates only the host copy. `reg_rd_data` and `eff_ctrl` both show it in the cycle after the write.
- R3: A guest-entry strobe in host mode issues a read request (`mem_req_write` = 0) to `cb_base + 0x6E0`, which is save-area offset 0x400 plus slot 0x2E0. While the fetch is pending, `guest_mode` stays 0, `busy` is 1 and `eff_ctrl` equals the host copy. In the cycle after the response is taken, `guest_mode` is 1 and the guest copy holds the response data.
- R4: In guest mode `eff_ctrl` is the bitwise OR of the host copy and the guest copy.
- R5: In guest mode a register write updates only the guest copy, and `reg_rd_data` returns the guest copy rather than the OR. The host copy is unchanged, which can be seen after exit.
- R6: A guest-exit strobe in guest mode issues a write request (`mem_req_write` = 1) of the guest copy to `cb_base + 0x6E0`. `guest_mode` stays 1 until the write response is taken and is 0 in the next cycle. `eff_ctrl` then equals the host copy alone.
- R7: An entry strobe in guest mode, or an exit strobe in host mode, changes no mode and no copy and sets `proto_err`. The flag stays set until reset.
- R8: While `busy` is 1, mode strobes and register writes are ignored and raise no error.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request valid, address, direction and data stay stable.
- R10: `cap_edx` reads with bit 20 set and every other bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cb_base | input | 64 | Control-block base address, 4 KiB aligned |
| enter_stb | input | 1 | Guest-entry strobe |
| exit_stb | input | 1 | Guest-exit strobe |
| reg_wr_en | input | 1 | Register write enable |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_data | output | 64 | Copy visible in the current mode |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 64 | Request byte address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Response valid (read data or write acknowledge) |
| mem_rsp_ready | output | 1 | Response ready, high while a response is awaited |
| mem_rsp_rdata | input | 64 | Read response data |
| eff_ctrl | output | 64 | Effective speculation-control word |
| guest_mode | output | 1 | Guest copy in effect |
| busy | output | 1 | Mode switch in progress |
| proto_err | output | 1 | Sticky protocol-error flag |
| cap_edx | output | 32 | Capability word reporting the feature |

## Verification
A register write or a mode strobe is taken at a clock edge, and its result shows at the outputs straight after that edge. The memory model raises a response one cycle after it accepts a request. With the memory ready, an entry or an exit therefore completes three edges after its strobe. The first edge raises the request, the second completes the handshake, and the third takes the response and switches the mode. The bench drives inputs and samples outputs on falling edges, and it checks busy, the unchanged mode and the effective word at each of those intermediate samples. It also holds ready low across several cycles to confirm that the request stays stable.

// File: rtl/spec_bank_pkg.sv
package spec_bank_pkg;
  typedef enum logic [2:0] {
    ST_HOST    = 3'd0,
    ST_ENT_REQ = 3'd1,
    ST_ENT_RSP = 3'd2,
    ST_GUEST   = 3'd3,
    ST_EXT_REQ = 3'd4,
    ST_EXT_RSP = 3'd5
  } mode_st_e;
endpackage

// File: rtl/spec_mode_fsm.sv
module spec_mode_fsm
  import spec_bank_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int SAVE_OFS = 'h400,
  parameter int SLOT_OFS = 'h2E0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cb_base,
  input  logic              enter_stb,
  input  logic              exit_stb,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] guest_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  output logic              load_guest,
  output logic              clear_guest,
  output logic              wr_accept,
  output logic              wr_to_guest,
  output logic              guest_mode,
  output logic              busy,
  output logic              proto_err
);
  localparam logic [ADDR_W-1:0] SLOT_ADDR_OFS = ADDR_W'(SAVE_OFS + SLOT_OFS);

  mode_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HOST;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_HOST: begin
          if (exit_stb) err_q <= 1'b1;
          else if (enter_stb) begin
            st_q   <= ST_ENT_REQ;
            addr_q <= cb_base + SLOT_ADDR_OFS;
          end
        end
        ST_ENT_REQ: if (mem_req_ready) st_q <= ST_ENT_RSP;
        ST_ENT_RSP: if (mem_rsp_valid) st_q <= ST_GUEST;
        ST_GUEST: begin
          if (enter_stb) err_q <= 1'b1;
          else if (exit_stb) begin
            st_q   <= ST_EXT_REQ;
            addr_q <= cb_base + SLOT_ADDR_OFS;
          end
        end
        ST_EXT_REQ: if (mem_req_ready) st_q <= ST_EXT_RSP;
        ST_EXT_RSP: if (mem_rsp_valid) st_q <= ST_HOST;
        default:    st_q <= ST_HOST;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (st_q == ST_ENT_REQ) || (st_q == ST_EXT_REQ);
    mem_req_write = (st_q == ST_EXT_REQ);
    mem_req_addr  = addr_q;
    mem_req_wdata = guest_word;
    mem_rsp_ready = (st_q == ST_ENT_RSP) || (st_q == ST_EXT_RSP);
    load_guest    = (st_q == ST_ENT_RSP) && mem_rsp_valid;
    clear_guest   = (st_q == ST_EXT_RSP) && mem_rsp_valid;
    guest_mode    = (st_q == ST_GUEST) || (st_q == ST_EXT_REQ) || (st_q == ST_EXT_RSP);
    busy          = !((st_q == ST_HOST) || (st_q == ST_GUEST));
    wr_accept     = reg_wr_en && !busy;
    wr_to_guest   = (st_q == ST_GUEST);
    proto_err     = err_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R9
  AST_ENTRY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guest_mode) |-> $past(mem_rsp_valid)); // R3
  AST_EXIT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(guest_mode) |-> $past(mem_rsp_valid)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R7
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy); // R3
endmodule

// File: rtl/spec_copy_regs.sv
module spec_copy_regs #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic              wr_to_guest,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load_guest,
  input  logic [DATA_W-1:0] load_data,
  input  logic              clear_guest,
  output logic [DATA_W-1:0] host_q,
  output logic [DATA_W-1:0] guest_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q  <= '0;
      guest_q <= '0;
    end else begin
      if (wr_accept && !wr_to_guest) host_q <= wr_data;
      if (wr_accept && wr_to_guest)  guest_q <= wr_data;
      else if (load_guest)           guest_q <= load_data;
      else if (clear_guest)          guest_q <= '0;
    end
  end

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_guest && wr_accept)); // R8
endmodule

// File: rtl/spec_eff_mux.sv
module spec_eff_mux #(
  parameter int DATA_W = 64
) (
  input  logic              guest_mode,
  input  logic [DATA_W-1:0] host_q,
  input  logic [DATA_W-1:0] guest_q,
  output logic [DATA_W-1:0] eff_ctrl,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign eff_ctrl[b] = host_q[b] | (guest_mode & guest_q[b]);
    assign rd_data[b]  = guest_mode ? guest_q[b] : host_q[b];
  end
endmodule

// File: rtl/spec_ctrl_bank.sv
module spec_ctrl_bank #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 64,
  parameter int SAVE_OFS = 'h400,
  parameter int SLOT_OFS = 'h2E0,
  parameter int CAP_W    = 32,
  parameter int FEAT_BIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cb_base,
  input  logic              enter_stb,
  input  logic              exit_stb,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  output logic [DATA_W-1:0] eff_ctrl,
  output logic              guest_mode,
  output logic              busy,
  output logic              proto_err,
  output logic [CAP_W-1:0]  cap_edx
);
  localparam logic [CAP_W-1:0] CAP_WORD = CAP_W'(1) << FEAT_BIT;

  logic              load_guest, clear_guest, wr_accept, wr_to_guest;
  logic [DATA_W-1:0] host_q, guest_q;

  assign cap_edx = CAP_WORD;

  spec_mode_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAVE_OFS(SAVE_OFS), .SLOT_OFS(SLOT_OFS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cb_base(cb_base),
    .enter_stb(enter_stb), .exit_stb(exit_stb), .reg_wr_en(reg_wr_en),
    .guest_word(guest_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .load_guest(load_guest),
    .clear_guest(clear_guest), .wr_accept(wr_accept), .wr_to_guest(wr_to_guest),
    .guest_mode(guest_mode), .busy(busy), .proto_err(proto_err)
  );

  spec_copy_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wr_to_guest(wr_to_guest),
    .wr_data(reg_wr_data), .load_guest(load_guest), .load_data(mem_rsp_rdata),
    .clear_guest(clear_guest), .host_q(host_q), .guest_q(guest_q)
  );

  AST_HOST_HELD_IN_GUEST: assert property (@(posedge clk) disable iff (!rst_n)
    guest_mode |=> $stable(host_q)); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load_guest && !clear_guest) |=> ($stable(guest_q) && $stable(host_q))); // R8
  AST_REQ_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_wdata)); // R9

  spec_eff_mux #(.DATA_W(DATA_W)) u_mux (
    .guest_mode(guest_mode), .host_q(host_q), .guest_q(guest_q),
    .eff_ctrl(eff_ctrl), .rd_data(reg_rd_data)
  );
endmodule

// File: tb/spec_ctrl_bank_tb.sv
module spec_ctrl_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cb_base = 64'h0;
  logic        enter_stb = 1'b0, exit_stb = 1'b0, reg_wr_en = 1'b0;
  logic [63:0] reg_wr_data = 64'h0;
  logic [63:0] reg_rd_data, mem_req_addr, mem_req_wdata, eff_ctrl;
  logic        mem_req_valid, mem_req_write, mem_rsp_ready;
  logic        guest_mode, busy, proto_err;
  logic [31:0] cap_edx;
  logic        mem_ready = 1'b1;
  logic        rsp_valid;
  logic [63:0] rsp_data, mem_word, last_addr, last_wdata;
  logic        last_write;
  int          n_checks = 0, n_fails = 0;

  always #10 clk = ~clk;

  spec_ctrl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cb_base(cb_base), .enter_stb(enter_stb),
    .exit_stb(exit_stb), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_rdata(rsp_data), .eff_ctrl(eff_ctrl), .guest_mode(guest_mode),
    .busy(busy), .proto_err(proto_err), .cap_edx(cap_edx)
  );

  // Single-slot memory: answers one cycle after accepting a request.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_data <= '0;
      last_addr <= '0; last_wdata <= '0; last_write <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (mem_req_valid && mem_ready) begin
        rsp_valid  <= 1'b1;
        last_addr  <= mem_req_addr;
        last_write <= mem_req_write;
        if (mem_req_write) begin
          mem_word   <= mem_req_wdata;
          last_wdata <= mem_req_wdata;
        end else rsp_data <= mem_word;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [63:0] v);
    reg_wr_en = 1'b1; reg_wr_data = v; tick(); reg_wr_en = 1'b0;
  endtask

  task automatic do_enter(input logic [63:0] host_v);
    enter_stb = 1'b1; tick(); enter_stb = 1'b0;
    chk("R3 busy during fetch", {63'h0, busy}, 64'h1);
    chk("R3 read request", {63'h0, mem_req_write}, 64'h0);
    chk("R3 address", mem_req_addr, cb_base + 64'h6E0);
    tick();
    chk("R3 host mode while fetching", {63'h0, guest_mode}, 64'h0);
    chk("R3 eff host during fetch", eff_ctrl, host_v);
    tick();
    chk("R3 guest mode after rsp", {62'h0, guest_mode, busy}, 64'h2);
  endtask

  task automatic do_exit(input logic [63:0] or_v);
    exit_stb = 1'b1; tick(); exit_stb = 1'b0;
    tick();
    chk("R6 guest mode held until ack", {63'h0, guest_mode}, 64'h1);
    chk("R6 eff still OR before ack", eff_ctrl, or_v);
    tick();
    chk("R6 host mode after ack", {62'h0, guest_mode, busy}, 64'h0);
    chk("R6 write request", {63'h0, last_write}, 64'h1);
    chk("R6 write address", last_addr, cb_base + 64'h6E0);
  endtask

  // base, host value, memory guest value, guest write value
  localparam logic [255:0] VEC [4] = '{
    {64'h0000_0000_0010_0000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0002},
    {64'h0000_7FFF_FFFF_F000, 64'h0000_0000_0000_0000, 64'hA5A5_0000_0000_5A5A, 64'h0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_E000, 64'hFFFF_0000_0000_0000, 64'h0000_0000_0000_FFFF, 64'h8000_0000_0000_0001},
    {64'h1234_5678_9ABC_D000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0F0F_0F0F_0F0F, 64'h1111_2222_3333_4444}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    mem_word = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 eff", eff_ctrl, 64'h0);
    chk("R1 read", reg_rd_data, 64'h0);
    chk("R1 flags", {61'h0, guest_mode, busy, proto_err}, 64'h0);
    // R10 capability
    chk("R10 cap", {32'h0, cap_edx}, 64'h0010_0000);

    for (int i = 0; i < 4; i++) begin
      logic [63:0] b, h, g, w;
      {b, h, g, w} = VEC[i];
      cb_base = b;
      reg_write(h);
      chk("R2 host read", reg_rd_data, h);
      chk("R2 host eff", eff_ctrl, h);
      mem_word = g;
      do_enter(h);
      chk("R3 loaded guest copy", reg_rd_data, g);
      chk("R4 eff OR on entry", eff_ctrl, h | g);
      reg_write(w);
      chk("R5 guest read returns guest copy", reg_rd_data, w);
      chk("R4 eff OR after guest write", eff_ctrl, h | w);
      do_exit(h | w);
      chk("R6 written guest copy", last_wdata, w);
      chk("R6 eff host alone", eff_ctrl, h);
      chk("R5 host copy untouched", reg_rd_data, h);
    end

    // R7 exit in host mode
    exit_stb = 1'b1; tick(); exit_stb = 1'b0;
    chk("R7 err on host exit", {61'h0, proto_err, guest_mode, busy}, 64'h4);
    chk("R7 no request", {63'h0, mem_req_valid}, 64'h0);
    reg_write(64'h0000_0000_0000_0008);
    mem_word = 64'h10;
    do_enter(64'h8);
    enter_stb = 1'b1; tick(); enter_stb = 1'b0;
    chk("R7 enter in guest ignored", {61'h0, proto_err, guest_mode, busy}, 64'h6);
    chk("R7 guest copy kept", reg_rd_data, 64'h10);
    tick();
    chk("R7 sticky", {63'h0, proto_err}, 64'h1);
    do_exit(64'h18);
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    chk("R1 reset clears err and copies", {proto_err, eff_ctrl[62:0]}, 64'h0);

    // R8 events during busy
    cb_base = 64'h0000_0000_0004_0000;
    reg_write(64'h3);
    mem_word = 64'h30;
    enter_stb = 1'b1; tick(); enter_stb = 1'b0;
    reg_wr_en = 1'b1; reg_wr_data = 64'hDEAD; exit_stb = 1'b1; tick();
    reg_wr_en = 1'b0; exit_stb = 1'b0;
    tick();
    chk("R8 entry completes", {62'h0, guest_mode, busy}, 64'h2);
    chk("R8 busy write dropped", reg_rd_data, 64'h30);
    chk("R8 no error", {63'h0, proto_err}, 64'h0);
    exit_stb = 1'b1; tick(); exit_stb = 1'b0;
    enter_stb = 1'b1; reg_wr_en = 1'b1; reg_wr_data = 64'hBEEF; tick();
    enter_stb = 1'b0; reg_wr_en = 1'b0;
    tick();
    chk("R8 exit completes", {62'h0, guest_mode, busy}, 64'h0);
    chk("R8 host untouched", reg_rd_data, 64'h3);
    chk("R8 written back unchanged", last_wdata, 64'h30);
    chk("R8 no error on exit", {63'h0, proto_err}, 64'h0);

    // R9 back-pressure on the request channel
    mem_ready = 1'b0;
    mem_word = 64'h40;
    enter_stb = 1'b1; tick(); enter_stb = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9 valid held", {63'h0, mem_req_valid}, 64'h1);
      chk("R9 addr held", mem_req_addr, cb_base + 64'h6E0);
      chk("R9 still host", {63'h0, guest_mode}, 64'h0);
    end
    mem_ready = 1'b1;
    tick(); tick();
    chk("R9 entry after release", {63'h0, guest_mode}, 64'h1);
    chk("R9 loaded value", reg_rd_data, 64'h40);
    chk("R4 OR after stall", eff_ctrl, 64'h43);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule